// File: doc/BRIEF.md
# Light-Load Sleep Supervisor for a Two-Channel Synchronous Rectifier

This block decides when a two-channel synchronous rectifier controller should stop driving its gates because the load is light, and when it should start driving them again. The analog comparators and the gate state machines sit outside the block. They deliver, for each channel:

- a pulse when a switching cycle starts (the drain has fallen through the pre-trigger level);
- a pulse when the cycle ends (the drain has risen through the arming level);
- a level that is high while the drain is below the turn-on level;
- the gate state.

A per-cycle current-reversal flag also arrives with the cycle-end pulses.

For every cycle the block counts the clock ticks of the whole cycle and of the conduction interval. It compares the two counts against two fixed fractions, without a divider. It keeps runs of consecutive qualifying cycles for each channel. After every change of mode it ignores decisions for a fixed number of converter cycles. A single `sleepOut` level tells the gate logic to stay off.

Top module: `sr_sleep_supervisor`

## Requirements
- R1: After reset `sleepOut` is 0 and no blanking is active, so the first qualifying run can change the mode.
- R2: A completed channel cycle qualifies for entry when conduction×10 < cycle×4, where both counts are ticks between the start pulse and the end pulse. The comparison is strict, so exactly 40 % does not qualify.
- R3: While awake and not blanked, `sleepOut` rises one clock after the cycle-end pulse that completes ENTRY_N consecutive entry-qualifying cycles on either channel.
- R4: Any completed cycle that does not qualify restarts that channel's consecutive count from zero.
- R5: While asleep and not blanked, `sleepOut` falls one clock after both channels have EXIT_N consecutive cycles with conduction×10 > cycle×6. The comparison is strict, so exactly 60 % does not qualify.
- R6: After entering sleep, the next BLANK_SLEEP cycle-end pulses of channel 0 cannot wake the block.
- R7: After waking, the next BLANK_WAKE cycle-end pulses of channel 0 cannot put the block to sleep through the duty test.
- R8: Consecutive counts keep accumulating during blanking and are cleared at every mode change. If a count already meets its target when blanking ends, the mode changes on the next clock.
- R9: While awake, conduction runs from the first tick with the drain below the turn-on level up to the tick before the gate falls. Drain-low ticks after the gate falls are excluded. While asleep, conduction is the number of ticks with the drain below the turn-on level.
- R10: While awake, a reversal flag sampled with two consecutive cycle-end pulses (either channel) forces sleep one clock later, even during blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycStart | input | NUM_CH | Per-channel cycle-start pulse |
| cycEnd | input | NUM_CH | Per-channel cycle-end pulse |
| drainLow | input | NUM_CH | Drain below the turn-on level |
| gateOn | input | NUM_CH | Gate driver state |
| revIn | input | 1 | Current-reversal flag, sampled with any cycle-end pulse |
| sleepOut | output | 1 | High while gate driving is suspended |

## Verification
The bench builds the block with ENTRY_N=4, EXIT_N=3, BLANK_SLEEP=5, BLANK_WAKE=7 and a counter width of 8. It runs 25-tick cycles, so every duty value from 8 % to 88 % can be swept for both the entry and the exit decision. This includes the exact 40 % and 60 % boundaries. The short blanking windows mean that blank expiry with a run already met, waiting after expiry, and reversal during blanking each take only a few dozen cycles. Each channel is driven with the waveform of the current mode, so a wrong conduction definition shifts a measured duty across a threshold.

// File: rtl/sr_sleep_pkg.sv
package sr_sleep_pkg;
  typedef struct packed {
    logic asleep;
    logic clearRuns;
  } ctrlStrobe_t;

  typedef struct packed {
    logic entryAny;
    logic exitAll;
  } chanStat_t;
endpackage

// File: rtl/sr_sleep_chan.sv
module sr_sleep_chan
  import sr_sleep_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ENTRY_N   = 16,
  parameter int EXIT_N    = 8,
  parameter int LOW_NUM   = 4,
  parameter int HIGH_NUM  = 6,
  parameter int RATIO_DEN = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        endPulse,
  input  logic        drainLow,
  input  logic        gateOn,
  input  ctrlStrobe_t strobe,
  output logic        entryMet,
  output logic        exitMet
);
  localparam int ER_W   = $clog2(ENTRY_N + 1);
  localparam int XR_W   = $clog2(EXIT_N + 1);
  localparam int PROD_W = CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             running, seen, done, gatePrev;
  logic [CNT_W-1:0] cycCnt, condCnt;
  logic [ER_W-1:0]  entryRun;
  logic [XR_W-1:0]  exitRun;
  logic             gateFall, condNow, lowQual, highQual, evalNow;
  logic [PROD_W-1:0] condScaled, lowLim, highLim;

  always_comb begin
    gateFall   = gatePrev & ~gateOn;
    condNow    = strobe.asleep ? drainLow
                               : (~done & ~gateFall & (drainLow | seen | gateOn));
    condScaled = PROD_W'(condCnt) * PROD_W'(RATIO_DEN);
    lowLim     = PROD_W'(cycCnt) * PROD_W'(LOW_NUM);
    highLim    = PROD_W'(cycCnt) * PROD_W'(HIGH_NUM);
    lowQual    = (cycCnt != '0) && (condScaled < lowLim);
    highQual   = (cycCnt != '0) && (condScaled > highLim);
    evalNow    = endPulse & running & ~startPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      seen     <= 1'b0;
      done     <= 1'b0;
      gatePrev <= 1'b0;
      cycCnt   <= '0;
      condCnt  <= '0;
      entryRun <= '0;
      exitRun  <= '0;
    end else begin
      gatePrev <= gateOn;
      if (startPulse) begin
        running <= 1'b1;
        cycCnt  <= '0;
        condCnt <= '0;
        seen    <= 1'b0;
        done    <= 1'b0;
      end else if (endPulse) begin
        running <= 1'b0;
      end else if (running) begin
        if (cycCnt != CNT_MAX) cycCnt <= cycCnt + 1'b1;
        if (condNow && condCnt != CNT_MAX) condCnt <= condCnt + 1'b1;
        if (drainLow) seen <= 1'b1;
        if (gateFall) done <= 1'b1;
      end

      if (strobe.clearRuns) begin
        entryRun <= '0;
        exitRun  <= '0;
      end else if (evalNow) begin
        if (!lowQual) entryRun <= '0;
        else if (entryRun != ER_W'(ENTRY_N)) entryRun <= entryRun + 1'b1;
        if (!highQual) exitRun <= '0;
        else if (exitRun != XR_W'(EXIT_N)) exitRun <= exitRun + 1'b1;
      end
    end
  end

  assign entryMet = (entryRun >= ER_W'(ENTRY_N));
  assign exitMet  = (exitRun >= XR_W'(EXIT_N));
endmodule

// File: rtl/sr_sleep_datapath.sv
module sr_sleep_datapath
  import sr_sleep_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 12,
  parameter int ENTRY_N   = 16,
  parameter int EXIT_N    = 8,
  parameter int LOW_NUM   = 4,
  parameter int HIGH_NUM  = 6,
  parameter int RATIO_DEN = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cycStart,
  input  logic [NUM_CH-1:0] cycEnd,
  input  logic [NUM_CH-1:0] drainLow,
  input  logic [NUM_CH-1:0] gateOn,
  input  ctrlStrobe_t       strobe,
  output chanStat_t         stat
);
  logic [NUM_CH-1:0] entryVec, exitVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    sr_sleep_chan #(
      .CNT_W(CNT_W), .ENTRY_N(ENTRY_N), .EXIT_N(EXIT_N),
      .LOW_NUM(LOW_NUM), .HIGH_NUM(HIGH_NUM), .RATIO_DEN(RATIO_DEN)
    ) u_chan (
      .clk(clk), .rstN(rstN),
      .startPulse(cycStart[ch]), .endPulse(cycEnd[ch]),
      .drainLow(drainLow[ch]), .gateOn(gateOn[ch]),
      .strobe(strobe),
      .entryMet(entryVec[ch]), .exitMet(exitVec[ch])
    );
  end

  assign stat.entryAny = |entryVec;
  assign stat.exitAll  = &exitVec;
endmodule

// File: rtl/sr_sleep_ctrl.sv
module sr_sleep_ctrl
  import sr_sleep_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int BLANK_SLEEP = 128,
  parameter int BLANK_WAKE  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cycEnd,
  input  logic              revIn,
  input  chanStat_t         stat,
  output ctrlStrobe_t       strobe,
  output logic              sleepOut
);
  localparam int BLK_MAX = (BLANK_SLEEP > BLANK_WAKE) ? BLANK_SLEEP : BLANK_WAKE;
  localparam int BLK_W   = $clog2(BLK_MAX + 1);
  localparam logic [1:0] REV_N = 2'd2;

  logic             asleep;
  logic [BLK_W-1:0] blankCnt;
  logic [1:0]       revCnt;
  logic             blankZero, anyEnd, goSleep, goWake;

  always_comb begin
    blankZero = (blankCnt == '0);
    anyEnd    = |cycEnd;
    goSleep   = ~asleep & ((revCnt >= REV_N) | (blankZero & stat.entryAny));
    goWake    = asleep & blankZero & stat.exitAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asleep   <= 1'b0;
      blankCnt <= '0;
      revCnt   <= '0;
    end else if (goSleep) begin
      asleep   <= 1'b1;
      blankCnt <= BLK_W'(BLANK_SLEEP);
      revCnt   <= '0;
    end else if (goWake) begin
      asleep   <= 1'b0;
      blankCnt <= BLK_W'(BLANK_WAKE);
      revCnt   <= '0;
    end else begin
      if (cycEnd[0] && !blankZero) blankCnt <= blankCnt - 1'b1;
      if (asleep) revCnt <= '0;
      else if (anyEnd) begin
        if (!revIn) revCnt <= '0;
        else if (revCnt != REV_N) revCnt <= revCnt + 1'b1;
      end
    end
  end

  assign strobe.asleep    = asleep;
  assign strobe.clearRuns = goSleep | goWake;
  assign sleepOut         = asleep;
endmodule

// File: rtl/sr_sleep_supervisor.sv
module sr_sleep_supervisor
  import sr_sleep_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 12,
  parameter int ENTRY_N     = 16,
  parameter int EXIT_N      = 8,
  parameter int BLANK_SLEEP = 128,
  parameter int BLANK_WAKE  = 256,
  parameter int LOW_NUM     = 4,
  parameter int HIGH_NUM    = 6,
  parameter int RATIO_DEN   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cycStart,
  input  logic [NUM_CH-1:0] cycEnd,
  input  logic [NUM_CH-1:0] drainLow,
  input  logic [NUM_CH-1:0] gateOn,
  input  logic              revIn,
  output logic              sleepOut
);
  ctrlStrobe_t ctrlStrobe;
  chanStat_t   chanStat;

  sr_sleep_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ENTRY_N(ENTRY_N), .EXIT_N(EXIT_N),
    .LOW_NUM(LOW_NUM), .HIGH_NUM(HIGH_NUM), .RATIO_DEN(RATIO_DEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycEnd(cycEnd),
    .drainLow(drainLow), .gateOn(gateOn), .strobe(ctrlStrobe), .stat(chanStat)
  );

  sr_sleep_ctrl #(
    .NUM_CH(NUM_CH), .BLANK_SLEEP(BLANK_SLEEP), .BLANK_WAKE(BLANK_WAKE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cycEnd(cycEnd), .revIn(revIn),
    .stat(chanStat), .strobe(ctrlStrobe), .sleepOut(sleepOut)
  );
endmodule

// File: rtl/sr_sleep_checker.sv
module sr_sleep_checker
  import sr_sleep_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cycEnd,
  input logic              sleepOut,
  input chanStat_t         stat,
  input ctrlStrobe_t       strobe,
  input logic [1:0]        revCnt
);
  // R8
  runs_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRuns |=> (!stat.entryAny && !stat.exitAll));

  // R3
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> ($past(stat.entryAny) || ($past(revCnt) >= 2'd2)));

  // R5
  exit_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepOut) |-> $past(stat.exitAll));

  // R6
  change_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepOut != $past(sleepOut)) |-> ($past(cycEnd, 2) != '0));

  // R10
  rev_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    revCnt <= 2'd2);
endmodule

bind sr_sleep_supervisor sr_sleep_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .cycEnd(cycEnd), .sleepOut(sleepOut),
  .stat(chanStat), .strobe(ctrlStrobe), .revCnt(u_ctrl.revCnt)
);

// File: tb/sr_sleep_supervisor_bench.sv
module sr_sleep_supervisor_bench;
  localparam int EN = 4;
  localparam int EX = 3;
  localparam int BS = 5;
  localparam int BW = 7;
  localparam int P  = 25;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cycStart = '0, cycEnd = '0, drainLow = '0, gateOn = '0;
  logic       revIn = 1'b0;
  logic       sleepOut;

  always #5 clk = ~clk;

  sr_sleep_supervisor #(
    .NUM_CH(2), .CNT_W(8), .ENTRY_N(EN), .EXIT_N(EX),
    .BLANK_SLEEP(BS), .BLANK_WAKE(BW)
  ) u_sr_sleep_supervisor (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycEnd(cycEnd),
    .drainLow(drainLow), .gateOn(gateOn), .revIn(revIn), .sleepOut(sleepOut)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  bit mSleep;
  int mEr[2], mXr[2], mBlank, mRev;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sleepOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cycStart = '0; cycEnd = '0; drainLow = '0; gateOn = '0; revIn = 1'b0;
    mSleep = 0; mBlank = 0; mRev = 0;
    mEr[0] = 0; mEr[1] = 0; mXr[0] = 0; mXr[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Reference decision from the requirements, applied after each cycle-end
  task automatic modelStep(int ch, int c, bit rev);
    bit low, high;
    low  = (c * 10) < (P * 4);
    high = (c * 10) > (P * 6);
    mEr[ch] = low  ? mEr[ch] + 1 : 0;
    mXr[ch] = high ? mXr[ch] + 1 : 0;
    if (ch == 0 && mBlank > 0) mBlank--;
    if (mSleep) mRev = 0;
    else mRev = rev ? mRev + 1 : 0;
    if (!mSleep && (mRev >= 2 || (mBlank == 0 && (mEr[0] >= EN || mEr[1] >= EN)))) begin
      mSleep = 1; mBlank = BS; mRev = 0;
      mEr[0] = 0; mEr[1] = 0; mXr[0] = 0; mXr[1] = 0;
    end else if (mSleep && mBlank == 0 && mXr[0] >= EX && mXr[1] >= EX) begin
      mSleep = 0; mBlank = BW; mRev = 0;
      mEr[0] = 0; mEr[1] = 0; mXr[0] = 0; mXr[1] = 0;
    end
  endtask

  // One cycle of length P on channel ch with conduction c (2..22)
  task automatic runCycle(int ch, int c, bit rev, string req);
    cycStart[ch] = 1'b1;
    @(negedge clk);
    cycStart[ch] = 1'b0;
    for (int k = 0; k < P; k++) begin
      if (mSleep) begin
        drainLow[ch] = (k < c);
        gateOn[ch]   = 1'b0;
      end else begin
        // R9: drain dips, gate conducts, then body diode again after gate off
        drainLow[ch] = (k == 0) || (k >= c && k < c + 3);
        gateOn[ch]   = (k >= 1 && k < c);
      end
      @(negedge clk);
    end
    drainLow[ch] = 1'b0; gateOn[ch] = 1'b0;
    cycEnd[ch] = 1'b1; revIn = rev;
    @(negedge clk);
    cycEnd[ch] = 1'b0; revIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    modelStep(ch, c, rev);
    check(req, sleepOut, mSleep);
  endtask

  task automatic runPair(int c0, int c1, string req);
    runCycle(0, c0, 1'b0, req);
    runCycle(1, c1, 1'b0, req);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    check("R1", sleepOut, 1'b0);

    // R2 sweep of entry duty on channel 0, channel 1 neutral (48 %)
    for (int c = 2; c <= 22; c++) begin
      doReset();
      for (int n = 0; n < EN; n++) runPair(c, 12, "R2");
    end

    // R5 and R9 sweep of exit duty on channel 0, channel 1 high
    for (int c = 2; c <= 22; c++) begin
      doReset();
      for (int n = 0; n < EN; n++) runPair(4, 4, "R3");
      for (int n = 0; n < BS + EX + 1; n++) runPair(c, 20, "R5/R9");
    end

    // R3 entry through channel 1 alone
    doReset();
    for (int n = 0; n < EN; n++) runPair(12, 5, "R3");

    // R4 a neutral cycle restarts the run
    doReset();
    for (int n = 0; n < EN - 1; n++) runPair(5, 12, "R4");
    runPair(12, 12, "R4");
    for (int n = 0; n < EN - 1; n++) runPair(5, 12, "R4");
    runPair(5, 12, "R4");

    // R6 and R8: high duty during blanking, wake right at blank end
    doReset();
    for (int n = 0; n < EN; n++) runPair(4, 4, "R3");
    for (int n = 0; n < BS + 1; n++) runPair(20, 20, "R6/R8");

    // R7: low duty right after waking, sleep only when blanking ends
    for (int n = 0; n < BW + 2; n++) runPair(4, 4, "R7/R8");

    // R8: neutral through blanking, then wait for a fresh exit run
    for (int n = 0; n < BS + 1; n++) runPair(12, 12, "R8");
    for (int n = 0; n < EX + 1; n++) runPair(20, 20, "R8");

    // R10: isolated reversal flags do nothing, two in a row force sleep
    runCycle(0, 12, 1'b1, "R10");
    runCycle(1, 12, 1'b0, "R10");
    runCycle(0, 12, 1'b1, "R10");
    runCycle(1, 12, 1'b0, "R10");
    runCycle(0, 12, 1'b1, "R10");
    runCycle(1, 12, 1'b1, "R10");
    for (int n = 0; n < 2; n++) runPair(12, 12, "R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule